// File: doc/BRIEF.md
# Field parity detector

This clocked block tells odd fields of an interlaced picture from even ones. It takes two inputs. The first is a sliced composite sync that is active low and sampled to the system clock. The second is an active-low vertical pulse that another block already produces. From the sync input the block keeps a horizontal reference that runs at line rate like a flywheel. It realigns only on sync edges that arrive near the expected end of a line, so equalizing pulses at half-line spacing and isolated noise pulses do not move it. The reference therefore keeps its phase through the pre-equalizing, vertical and post-equalizing intervals.

The decision is made once per field, when the vertical pulse begins. If the reference is high at that moment, the vertical interval started with a line, and the field is odd. If the reference is low, the vertical interval started mid-line, and the field is even. The block latches the result into the output register and holds it until the next vertical pulse. It never counts lines, so extra pulses before the vertical interval cannot shift the result. After a reset the output reads even and is flagged invalid until one full vertical pulse has been seen.

Top module: `field_parity_det`

## Requirements
- R1: A synchronous reset (`rst` high at a rising clock edge) clears `odd_field`, `parity_valid` and `h_ref` to 0 on that edge, even in the middle of operation.
- R2: `csync_n` passes through a two-flop synchronizer. After an accepted falling sync edge, `h_ref` is high for exactly `HREF_CYC` cycles. It first reads high after the third rising edge, counting the edge that first samples `csync_n` low.
- R3: While no sync edge has been seen since reset, `h_ref` stays low. The first falling sync edge after reset is accepted whatever its timing, and it starts the reference.
- R4: A falling sync edge is accepted when the line-position counter is within `WIN_CYC` cycles of a line boundary, that is, at or above `LINE_CYC-WIN_CYC` or at or below `WIN_CYC`. An accepted edge realigns the reference to line start.
- R5: A falling sync edge outside that window is ignored and the reference keeps its free-running line period. This covers half-line equalizing and serration pulses and isolated noise pulses.
- R6: At a rising edge where `vsync_n` is sampled low after being high in the previous sample, the block latches the current value of `h_ref` as the parity. `odd_field` shows it after that edge: 1 means odd, 0 means even.
- R7: Apart from reset, `odd_field` changes only at a vertical asserting edge as in R6, or at the moment `parity_valid` is first set.
- R8: `parity_valid` stays 0 until the first rising edge of `vsync_n` that follows a latched vertical asserting edge. While `parity_valid` is 0, `odd_field` reads 0.
- R9: An extra pulse during the pre-equalizing interval does not change the parity reported for that field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| csync_n | input | 1 | Sliced composite sync, active low, not yet synchronized |
| vsync_n | input | 1 | Vertical sync pulse, active low, synchronous to `clk` |
| h_ref | output | 1 | Flywheel horizontal reference, high for the first `HREF_CYC` cycles of each line |
| odd_field | output | 1 | Field parity: 1 odd, 0 even; 0 while invalid |
| parity_valid | output | 1 | High once a complete vertical pulse has been seen |

## Verification
The reference lags a sync falling edge by three clock edges. Two of these come from the synchronizer and one from the position register. The parity appears one edge after `vsync_n` is first sampled low, and `parity_valid` appears one edge after `vsync_n` is first sampled high again. The bench drives every input on the falling clock edge and tracks its own line slot number. It reads `h_ref` at slots picked so that an aligned reference and a misaligned one give different values. It reads `odd_field` one slot after the vertical edge and also in the slot just before it, which shows that the output does not move early.

// File: rtl/field_parity_det.sv
module field_parity_det #(
  parameter int LINE_CYC = 8000,
  parameter int WIN_CYC  = 250,
  parameter int HREF_CYC = 2000
) (
  input  logic clk,
  input  logic rst,
  input  logic csync_n,
  input  logic vsync_n,
  output logic h_ref,
  output logic odd_field,
  output logic parity_valid
);
  localparam int PW = $clog2(LINE_CYC);
  localparam logic [PW-1:0] LAST   = PW'(LINE_CYC - 1);
  localparam logic [PW-1:0] WIN_LO = PW'(LINE_CYC - WIN_CYC);
  localparam logic [PW-1:0] WIN_HI = PW'(WIN_CYC);
  localparam logic [PW-1:0] HEND   = PW'(HREF_CYC);

  logic [2:0]    cs_sr;
  logic [PW-1:0] pos;
  logic          locked, vs_q, odd_r, seen_v, valid_r;

  wire sync_fall = cs_sr[2] & ~cs_sr[1];
  wire in_win    = (pos >= WIN_LO) || (pos <= WIN_HI);
  wire accept    = sync_fall && (!locked || in_win);
  wire v_fall    = vs_q & ~vsync_n;
  wire v_rise    = ~vs_q & vsync_n;

  always_ff @(posedge clk) begin
    if (rst) cs_sr <= 3'b111;
    else     cs_sr <= {cs_sr[1:0], csync_n};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos    <= '0;
      locked <= 1'b0;
    end else if (accept) begin
      pos    <= '0;
      locked <= 1'b1;
    end else if (pos == LAST) begin
      pos    <= '0;
    end else begin
      pos    <= pos + 1'b1;
    end
  end

  assign h_ref = locked && (pos < HEND);

  always_ff @(posedge clk) begin
    if (rst) begin
      vs_q    <= 1'b1;
      odd_r   <= 1'b0;
      seen_v  <= 1'b0;
      valid_r <= 1'b0;
    end else begin
      vs_q <= vsync_n;
      if (v_fall) begin
        odd_r  <= h_ref;
        seen_v <= 1'b1;
      end
      if (v_rise && seen_v) valid_r <= 1'b1;
    end
  end

  assign odd_field    = odd_r & valid_r;
  assign parity_valid = valid_r;
endmodule

module field_parity_det_chk (
  input logic clk,
  input logic rst,
  input logic vsync_n,
  input logic h_ref,
  input logic odd_field,
  input logic parity_valid
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (!odd_field && !parity_valid && !h_ref));

  // R8
  invalid_low_chk: assert property (@(posedge clk) disable iff (rst)
    !parity_valid |-> !odd_field);

  // R7
  update_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (!$stable(odd_field) && !$past(rst)) |->
      (($past(vsync_n, 2) && !$past(vsync_n)) || $rose(parity_valid) || $past(rst, 2)));

  // R6
  capture_value_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && $past(parity_valid) && $past(vsync_n, 2) && !$past(vsync_n))
      |-> (odd_field == $past(h_ref)));
endmodule

bind field_parity_det field_parity_det_chk u_chk (
  .clk(clk), .rst(rst), .vsync_n(vsync_n), .h_ref(h_ref),
  .odd_field(odd_field), .parity_valid(parity_valid)
);

// File: tb/field_parity_det_tb.sv
module field_parity_det_tb;
  localparam int LINE = 64;
  localparam int WIN  = 4;
  localparam int HREF = 16;
  localparam int SW   = 5;
  localparam int FLINES = 12;
  // bit 1: odd field expected, bit 0: extra pre-equalizing pulse
  localparam logic [1:0] FIELD_TBL [6] = '{2'b10, 2'b00, 2'b11, 2'b01, 2'b00, 2'b10};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic csync_n = 1'b1;
  logic vsync_n = 1'b1;
  logic h_ref, odd_field, parity_valid;

  int checks = 0;
  int fails = 0;
  int bpos = 0;
  int cur = 0;
  int line_len = LINE;
  int noise_at = -1;
  bit half_on = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  field_parity_det #(.LINE_CYC(LINE), .WIN_CYC(WIN), .HREF_CYC(HREF)) u_dut (
    .clk(clk), .rst(rst), .csync_n(csync_n), .vsync_n(vsync_n),
    .h_ref(h_ref), .odd_field(odd_field), .parity_valid(parity_valid)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b (time %0t)", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
    cur = bpos;
    csync_n = !((cur < SW) ||
                (half_on && cur >= LINE/2 && cur < LINE/2 + SW) ||
                (noise_at >= 0 && (cur == noise_at || cur == noise_at + 1)));
    bpos = (cur >= line_len - 1) ? 0 : cur + 1;
  endtask

  task automatic run_line();
    for (int i = 0; i < line_len; i++) step();
  endtask

  task automatic run_field(input bit odd, input bit extra, input bit first, input bit prev);
    int vs_start;
    int vs_end;
    vs_start = odd ? 5*LINE + 6 : 4*LINE + LINE/2 + 6;
    vs_end   = vs_start + 3*LINE;
    for (int idx = 0; idx < FLINES*LINE; idx++) begin
      int ln;
      ln = idx / LINE;
      half_on  = (ln >= 2 && ln <= 10);
      noise_at = (extra && ln == 3) ? LINE/4 : -1;
      step();
      if (idx == vs_start) vsync_n = 1'b0;
      if (idx == vs_end)   vsync_n = 1'b1;
      if (idx == vs_start) chk("R7 output held before vertical edge", odd_field, prev);
      if (idx == vs_start + 1) begin
        if (first) begin
          chk("R8 parity hidden while invalid", odd_field, 1'b0);
          chk("R8 valid low during first pulse", parity_valid, 1'b0);
        end else begin
          chk(extra ? "R9 parity with extra pre-eq pulse" : "R6 parity at vertical edge", odd_field, odd);
        end
      end
      if (first && idx == vs_end + 1) begin
        chk("R8 valid after first vertical pulse", parity_valid, 1'b1);
        chk("R8 parity shown once valid", odd_field, odd);
      end
      if (ln == 6 && cur == 3)          chk("R5 reference high at line start in vertical", h_ref, 1'b1);
      if (ln == 6 && cur == LINE/2 + 3) chk("R5 half-line edge ignored", h_ref, 1'b0);
      if (extra && ln == 3 && cur == LINE/4 + 4) chk("R5 noise pulse ignored", h_ref, 1'b0);
    end
    half_on  = 1'b0;
    noise_at = -1;
  endtask

  initial begin
    bit prev;
    repeat (3) @(negedge clk);
    chk("R1 odd_field in reset", odd_field, 1'b0);
    chk("R1 parity_valid in reset", parity_valid, 1'b0);
    chk("R1 h_ref in reset", h_ref, 1'b0);
    rst = 1'b0;
    repeat (10) @(negedge clk);
    chk("R3 no reference before first edge", h_ref, 1'b0);

    for (int i = 0; i < LINE; i++) begin
      step();
      if (cur == 2)            chk("R2 reference not early", h_ref, 1'b0);
      if (cur == 3)            chk("R3 first edge accepted", h_ref, 1'b1);
      if (cur == 3 + HREF - 1) chk("R2 reference width last", h_ref, 1'b1);
      if (cur == 3 + HREF)     chk("R2 reference width end", h_ref, 1'b0);
    end

    run_field(1'b1, 1'b0, 1'b1, 1'b0);
    prev = 1'b1;
    for (int f = 0; f < 6; f++) begin
      run_field(FIELD_TBL[f][1], FIELD_TBL[f][0], 1'b0, prev);
      prev = FIELD_TBL[f][1];
    end

    line_len = LINE - 2;
    run_line();
    line_len = LINE;
    for (int i = 0; i < LINE; i++) begin
      step();
      if (cur == 3) chk("R4 in-window edge realigns", h_ref, 1'b1);
    end

    line_len = LINE - 10;
    run_line();
    line_len = LINE + 10;
    for (int i = 0; i < LINE + 10; i++) begin
      step();
      if (cur == 3) chk("R5 out-of-window edge ignored", h_ref, 1'b0);
    end
    line_len = LINE;
    for (int i = 0; i < LINE; i++) begin
      step();
      if (cur == 3) chk("R4 realigned after restore", h_ref, 1'b1);
    end
    chk("R7 parity kept through line jitter", odd_field, prev);

    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 mid-run reset odd_field", odd_field, 1'b0);
    chk("R1 mid-run reset parity_valid", parity_valid, 1'b0);
    chk("R1 mid-run reset h_ref", h_ref, 1'b0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected done");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule